// File: doc/BRIEF.md
# Pulse Frequency and Rotational Speed Meter

This block sits behind a pulse counter front end and turns the stream of counted pulse events into a rate. A programmable cycle count sets the length of a gate window. When the window closes, the number of pulse events seen inside it is latched as the frequency. With a window of one second of clock cycles, that value is in hertz. The full-scale limit depends on the counter's input mode. The narrow limit applies in quadrature mode and the wide limit in every other mode. A count above the active limit is clipped and flagged.

After each window, one shared restoring divider runs two jobs in turn. The first turns the frequency into revolutions per minute using a programmable pulses-per-rotation value. The second turns the front end's accumulated count, sampled at the close of the window, into whole rotations. Each result has its own one-cycle valid strobe. A zero pulses-per-rotation value raises an error flag instead of starting the divider.

Top module: `pulse_rate_meter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all outputs are zero.
- R2: The window closes on every `gate_cycles`-th clock edge. `freq_out` then equals the number of those edges at which `pulse_evt` was high, and `freq_valid` is high for exactly the one cycle after the closing edge. The next window begins without a gap.
- R3: With `quad_mode`=1 at the closing edge, a count above 50000 is reported as 50000 with `over_range`=1.
- R4: With `quad_mode`=0 at the closing edge, a count above 100000 is reported as 100000 with `over_range`=1.
- R5: When the count is within the active limit, `over_range` is 0. `over_range` is re-evaluated at every window close.
- R6: After a window that closes with nonzero `ppr`, `rpm_out` becomes floor(`freq_out`×60/`ppr`), marked by a one-cycle `rpm_valid` pulse that follows `freq_valid`.
- R7: After `rpm_valid`, `rot_out` becomes floor(`count_val`/`ppr`), where `count_val` is the value present at the closing edge. This is marked by a one-cycle `rot_valid` pulse.
- R8: When `ppr` is 0 at the closing edge, `ppr_err` goes to 1, no `rpm_valid` or `rot_valid` follows, and `rpm_out` and `rot_out` keep their old values. The next window that closes with nonzero `ppr` clears `ppr_err`.
- R9: `freq_out`, `rpm_out` and `rot_out` change only in the cycle that their own valid strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_evt | input | 1 | One counted pulse event in this cycle |
| quad_mode | input | 1 | Counter front end is in quadrature mode |
| count_val | input | CNT_W | Accumulated pulse count from the front end |
| ppr | input | PPR_W | Pulses per rotation |
| gate_cycles | input | GATE_W | Window length in clock cycles |
| freq_out | output | FREQ_W | Pulses counted in the last window, clipped |
| freq_valid | output | 1 | One-cycle strobe: new frequency |
| over_range | output | 1 | Last window exceeded the active limit |
| rpm_out | output | FREQ_W+6 | Speed in revolutions per minute |
| rpm_valid | output | 1 | One-cycle strobe: new speed |
| rot_out | output | CNT_W | Total rotations |
| rot_valid | output | 1 | One-cycle strobe: new rotation count |
| ppr_err | output | 1 | Last window closed with zero pulses per rotation |

## Verification
The bench sweeps pulse spacings against a set of `ppr` values that includes 1 and the full-scale 65535, in both modes. These cases expose a divider that drops its final iteration, keeps a bad remainder, or truncates a wide divisor. Two long windows, each one pulse past its limit, check the mode-dependent clip. A design that applied a single limit would report the wrong value in one of the two modes. A design that counted off by one at the window edge would miss the clip entirely, because the count would equal the limit. A zero `ppr` window is watched for stray strobes and for changed outputs, and the following good window is checked to clear the flag. Each window's count is predicted from the exact edges the bench drives, so an off-by-one window length shows up in every sweep point.

// File: rtl/prm_pkg.sv
package prm_pkg;

    localparam int DEF_FREQ_W    = 17;
    localparam int DEF_PPR_W     = 16;
    localparam int DEF_CNT_W     = 24;
    localparam int DEF_GATE_W    = 27;
    localparam int DEF_FMAX_QUAD = 50000;
    localparam int DEF_FMAX_FULL = 100000;
    localparam int RPM_SCALE     = 60;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_RPM_GO,
        SEQ_RPM_WAIT,
        SEQ_ROT_GO,
        SEQ_ROT_WAIT
    } seq_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prm_window.sv
module prm_window #(
    parameter int FREQ_W    = prm_pkg::DEF_FREQ_W,
    parameter int GATE_W    = prm_pkg::DEF_GATE_W,
    parameter int FMAX_QUAD = prm_pkg::DEF_FMAX_QUAD,
    parameter int FMAX_FULL = prm_pkg::DEF_FMAX_FULL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_evt,
    input  logic              quad_mode,
    input  logic [GATE_W-1:0] gate_cycles,
    output logic              win_tick,
    output logic              win_end,
    output logic [FREQ_W-1:0] rate_q,
    output logic              clip_q
);
    logic [GATE_W-1:0] cyc;
    logic [FREQ_W-1:0] pcnt;
    logic [FREQ_W-1:0] pnext;
    logic [FREQ_W-1:0] limit;

    always_comb begin
        win_tick = ({1'b0, cyc} + (GATE_W+1)'(1)) >= {1'b0, gate_cycles};
        pnext    = (pulse_evt && (pcnt != '1)) ? pcnt + FREQ_W'(1) : pcnt;
        limit    = quad_mode ? FREQ_W'(FMAX_QUAD) : FREQ_W'(FMAX_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc     <= '0;
            pcnt    <= '0;
            rate_q  <= '0;
            clip_q  <= 1'b0;
            win_end <= 1'b0;
        end else begin
            win_end <= 1'b0;
            if (win_tick) begin
                cyc     <= '0;
                pcnt    <= '0;
                win_end <= 1'b1;
                if (pnext > limit) begin
                    rate_q <= limit;
                    clip_q <= 1'b1;
                end else begin
                    rate_q <= pnext;
                    clip_q <= 1'b0;
                end
            end else begin
                cyc  <= cyc + GATE_W'(1);
                pcnt <= pnext;
            end
        end
    end
endmodule

// File: rtl/prm_seq_div.sv
module prm_seq_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] dv;
    logic [CW-1:0]    left;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        shifted = {rem, quo[NUM_W-1]};
        diff    = shifted - {1'b0, dv};
        fits    = shifted >= {1'b0, dv};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            dv   <= '0;
            quo  <= '0;
            left <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem  <= '0;
                quo  <= num;
                dv   <= den;
                left <= CW'(NUM_W);
            end else if (left != '0) begin
                rem  <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                quo  <= {quo[NUM_W-2:0], fits};
                left <= left - CW'(1);
                if (left == CW'(1)) done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter #(
    parameter int FREQ_W    = prm_pkg::DEF_FREQ_W,
    parameter int PPR_W     = prm_pkg::DEF_PPR_W,
    parameter int CNT_W     = prm_pkg::DEF_CNT_W,
    parameter int GATE_W    = prm_pkg::DEF_GATE_W,
    parameter int FMAX_QUAD = prm_pkg::DEF_FMAX_QUAD,
    parameter int FMAX_FULL = prm_pkg::DEF_FMAX_FULL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pulse_evt,
    input  logic                quad_mode,
    input  logic [CNT_W-1:0]    count_val,
    input  logic [PPR_W-1:0]    ppr,
    input  logic [GATE_W-1:0]   gate_cycles,
    output logic [FREQ_W-1:0]   freq_out,
    output logic                freq_valid,
    output logic                over_range,
    output logic [FREQ_W+5:0]   rpm_out,
    output logic                rpm_valid,
    output logic [CNT_W-1:0]    rot_out,
    output logic                rot_valid,
    output logic                ppr_err
);
    import prm_pkg::*;

    localparam int RPM_W = FREQ_W + 6;
    localparam int NUM_W = max_int(RPM_W, CNT_W);

    logic               win_tick;
    logic [CNT_W-1:0]   cnt_snap;
    logic [PPR_W-1:0]   ppr_snap;
    seq_state_e         state;
    logic               div_start;
    logic               div_done;
    logic [NUM_W-1:0]   div_num;
    logic [NUM_W-1:0]   div_quo;

    prm_window #(
        .FREQ_W   (FREQ_W),
        .GATE_W   (GATE_W),
        .FMAX_QUAD(FMAX_QUAD),
        .FMAX_FULL(FMAX_FULL)
    ) u_window (
        .clk        (clk),
        .rst        (rst),
        .pulse_evt  (pulse_evt),
        .quad_mode  (quad_mode),
        .gate_cycles(gate_cycles),
        .win_tick   (win_tick),
        .win_end    (freq_valid),
        .rate_q     (freq_out),
        .clip_q     (over_range)
    );

    always_comb begin
        div_start = (state == SEQ_RPM_GO) || (state == SEQ_ROT_GO);
        if (state == SEQ_ROT_GO) div_num = NUM_W'(cnt_snap);
        else                     div_num = NUM_W'(freq_out) * NUM_W'(RPM_SCALE);
    end

    prm_seq_div #(
        .NUM_W(NUM_W),
        .DEN_W(PPR_W)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .start(div_start),
        .num  (div_num),
        .den  (ppr_snap),
        .done (div_done),
        .quo  (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            cnt_snap  <= '0;
            ppr_snap  <= '0;
            ppr_err   <= 1'b0;
            rpm_out   <= '0;
            rpm_valid <= 1'b0;
            rot_out   <= '0;
            rot_valid <= 1'b0;
        end else begin
            rpm_valid <= 1'b0;
            rot_valid <= 1'b0;
            if (win_tick) begin
                cnt_snap <= count_val;
                ppr_snap <= ppr;
                ppr_err  <= (ppr == '0);
                state    <= (ppr == '0) ? SEQ_IDLE : SEQ_RPM_GO;
            end else begin
                unique case (state)
                    SEQ_RPM_GO: state <= SEQ_RPM_WAIT;
                    SEQ_RPM_WAIT: if (div_done) begin
                        rpm_out   <= div_quo[RPM_W-1:0];
                        rpm_valid <= 1'b1;
                        state     <= SEQ_ROT_GO;
                    end
                    SEQ_ROT_GO: state <= SEQ_ROT_WAIT;
                    SEQ_ROT_WAIT: if (div_done) begin
                        rot_out   <= div_quo[CNT_W-1:0];
                        rot_valid <= 1'b1;
                        state     <= SEQ_IDLE;
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/prm_checker.sv
module prm_checker #(
    parameter int FREQ_W    = 17,
    parameter int CNT_W     = 24,
    parameter int FMAX_QUAD = 50000,
    parameter int FMAX_FULL = 100000
) (
    input logic              clk,
    input logic              rst,
    input logic [FREQ_W-1:0] freq_out,
    input logic              freq_valid,
    input logic              over_range,
    input logic [FREQ_W+5:0] rpm_out,
    input logic              rpm_valid,
    input logic [CNT_W-1:0]  rot_out,
    input logic              rot_valid,
    input logic              ppr_err
);
    AST_FREQ_CEILING: assert property (@(posedge clk) disable iff (rst)
        freq_valid |-> (freq_out <= FREQ_W'(FMAX_FULL))); // R4
    AST_CLIP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        over_range |-> ((freq_out == FREQ_W'(FMAX_QUAD)) || (freq_out == FREQ_W'(FMAX_FULL)))); // R3
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        ppr_err |-> (!rpm_valid && !rot_valid)); // R8
    AST_RPM_PULSE: assert property (@(posedge clk) disable iff (rst)
        rpm_valid |=> !rpm_valid); // R6
    AST_ROT_AFTER_RPM: assert property (@(posedge clk) disable iff (rst)
        rpm_valid |-> !rot_valid); // R7
    AST_FREQ_HELD: assert property (@(posedge clk) disable iff (rst)
        !freq_valid |-> $stable(freq_out)); // R9
    AST_RPM_HELD: assert property (@(posedge clk) disable iff (rst)
        !rpm_valid |-> $stable(rpm_out)); // R9
    AST_ROT_HELD: assert property (@(posedge clk) disable iff (rst)
        !rot_valid |-> $stable(rot_out)); // R9
endmodule

bind pulse_rate_meter prm_checker #(
    .FREQ_W   (FREQ_W),
    .CNT_W    (CNT_W),
    .FMAX_QUAD(FMAX_QUAD),
    .FMAX_FULL(FMAX_FULL)
) u_prm_checker (
    .clk       (clk),
    .rst       (rst),
    .freq_out  (freq_out),
    .freq_valid(freq_valid),
    .over_range(over_range),
    .rpm_out   (rpm_out),
    .rpm_valid (rpm_valid),
    .rot_out   (rot_out),
    .rot_valid (rot_valid),
    .ppr_err   (ppr_err)
);

// File: tb/test_pulse_rate_meter.sv
module test_pulse_rate_meter;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;
    localparam int BASE_GATE  = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pulse_evt = 1'b0;
    logic        quad_mode = 1'b0;
    logic [23:0] count_val = '0;
    logic [15:0] ppr = 16'd1;
    logic [26:0] gate_cycles = 27'(BASE_GATE);
    logic [16:0] freq_out;
    logic        freq_valid;
    logic        over_range;
    logic [22:0] rpm_out;
    logic        rpm_valid;
    logic [23:0] rot_out;
    logic        rot_valid;
    logic        ppr_err;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pulse_rate_meter i_pulse_rate_meter (
        .clk        (clk),
        .rst        (rst),
        .pulse_evt  (pulse_evt),
        .quad_mode  (quad_mode),
        .count_val  (count_val),
        .ppr        (ppr),
        .gate_cycles(gate_cycles),
        .freq_out   (freq_out),
        .freq_valid (freq_valid),
        .over_range (over_range),
        .rpm_out    (rpm_out),
        .rpm_valid  (rpm_valid),
        .rot_out    (rot_out),
        .rot_valid  (rot_valid),
        .ppr_err    (ppr_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_boundary();
        @(negedge clk);
        while (!freq_valid) @(negedge clk);
    endtask

    task automatic wait_strobe(input bit want_rot, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 200 && !seen; i++) begin
            @(negedge clk);
            seen = want_rot ? rot_valid : rpm_valid;
        end
    endtask

    // One measured window of g cycles, pulse on every step-th edge (none if step is 0)
    task automatic measure(input int g, input int step, input bit quad,
                           input int pprv, input int cntv);
        longint cnt = 0;
        longint lim = quad ? 50000 : 100000;
        longint ef;
        bit seen;
        wait_boundary();
        gate_cycles = 27'(g);
        quad_mode   = quad;
        ppr         = 16'(pprv);
        count_val   = 24'(cntv);
        for (int k = 0; k < g; k++) begin
            pulse_evt = (step != 0) && (k % step == 0);
            if (pulse_evt) cnt++;
            @(negedge clk);
        end
        pulse_evt = 1'b0;
        ef = (cnt > lim) ? lim : cnt;
        check("R2 freq_valid", freq_valid, 1);
        check(quad ? "R3 freq" : "R4 freq", freq_out, ef);
        check("R5 over_range", over_range, (cnt > lim) ? 1 : 0);
        gate_cycles = 27'(BASE_GATE);
        if (pprv != 0) begin
            check("R8 ppr_err clear", ppr_err, 0);
            wait_strobe(1'b0, seen);
            check("R6 rpm_valid seen", seen, 1);
            check("R6 rpm", rpm_out, (ef * 60) / pprv);
            @(negedge clk);
            check("R6 rpm_valid one cycle", rpm_valid, 0);
            wait_strobe(1'b1, seen);
            check("R7 rot_valid seen", seen, 1);
            check("R7 rot", rot_out, longint'(cntv) / pprv);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual %0d expected 0", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int pprs[6] = '{1, 2, 7, 60, 1000, 65535};
        int steps[5] = '{1, 2, 3, 7, 0};
        logic [22:0] rpm_keep;
        logic [23:0] rot_keep;
        bit stray;

        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 freq", freq_out, 0);
        check("R1 valids", {freq_valid, rpm_valid, rot_valid}, 0);
        check("R1 flags", {over_range, ppr_err}, 0);
        check("R1 rpm/rot", rpm_out + rot_out, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {freq_valid, rpm_valid, rot_valid, ppr_err}, 0);

        // R2 R5 R6 R7: sweep over spacing, ppr and mode
        for (int p = 0; p < 6; p++)
            for (int s = 0; s < 5; s++)
                measure(BASE_GATE, steps[s], (s + p) % 2 == 1, pprs[p],
                        (p * 2654435 + s * 1234567 + 97) % 16777216);

        // R8: zero ppr, outputs held and no strobes
        rpm_keep = rpm_out;
        rot_keep = rot_out;
        measure(BASE_GATE, 2, 1'b0, 0, 5000);
        check("R8 ppr_err set", ppr_err, 1);
        stray = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (rpm_valid || rot_valid) stray = 1'b1;
        end
        check("R8 no strobes", stray, 0);
        check("R8 rpm held", rpm_out, rpm_keep);
        check("R8 rot held", rot_out, rot_keep);
        measure(BASE_GATE, 4, 1'b0, 9, 999);

        // R3: one past the quadrature limit; R4: one past the wide limit
        measure(50001, 1, 1'b1, 3, 123456);
        measure(100001, 1, 1'b0, 7, 7000000);
        measure(BASE_GATE, 1, 1'b1, 5, 55);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule